// File: doc/BRIEF.md
# Pipelined Converter Digital Correction Combiner

This block sits behind a pipelined converter core built from fifteen redundant 1-bit stages. Every sample leaves one decision bit in each stage, and the stages work in sequence, so stage k's bit for a given sample arrives k clocks after stage 0's bit. The combiner delays each stage lane so that all fifteen bits of one sample meet in the same cycle. It then adds up a calibrated weight for every bit that is set and forms a 12-bit straight-binary code from that sum.

The weights are unsigned fixed-point values with four fractional bits. They are held in a small register file that calibration logic loads through a write port, and the port takes writes only while the calibration-active input is high. One extra signed entry adds a constant offset to every sum, which lets calibration correct zero error and gives the below-zero saturation path a real source. The rounded sum is clamped to the code range. The over-range flag is raised whenever the clamp acts, and a new word comes out on every clock.

Top module: `pipe_corr_combiner`

## Requirements
- R1: Bit k of sample s is presented on `stage_bits_i[k]` in cycle s+k. The word for sample s appears on the outputs at the second rising edge after the cycle in which stage 14's bit of that sample is presented.
- R2: The raw sum for a sample is the offset entry (16-bit two's complement) plus the 16-bit unsigned weight of every stage whose aligned bit is 1. All values are in units of 1/16 code. The weights used are those held during the cycle of stage 14's bit.
- R3: The code before clamping is floor((sum + 8) / 16), so a fraction of one half rounds upward.
- R4: When the rounded value is below 0, `code_o` is 0 and `over_range_o` is 1.
- R5: When the rounded value is above 4095, `code_o` is 4095 and `over_range_o` is 1.
- R6: When the rounded value lies in 0..4095, `code_o` equals it and `over_range_o` is 0.
- R7: A new independent word is produced on every clock, with no idle cycles between samples.
- R8: A write with `coef_we_i` high updates entry `coef_addr_i` at the rising edge only if `cal_active_i` is high. Addresses 0..14 select stage weights and address 15 selects the offset. Writes made while `cal_active_i` is low change no entry.
- R9: After reset, `code_o` and `over_range_o` are 0, the deskew lanes hold 0, weight k is 2^(15-k) (the ideal binary weight), and the offset is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stage_bits_i | input | 15 | Raw decision bit of each stage, bit k from stage k |
| cal_active_i | input | 1 | Calibration active; enables coefficient writes |
| coef_we_i | input | 1 | Coefficient write strobe |
| coef_addr_i | input | 4 | Entry to write: 0..14 stage weights, 15 offset |
| coef_wdata_i | input | 16 | Weight or offset value, 4 fractional bits |
| code_o | output | 12 | Corrected straight-binary output code |
| over_range_o | output | 1 | High when the code was clamped |

## Verification
The assertions check the clamping on every cycle: a rounded value below zero or above full scale must appear one edge later as 0 or 4095 with the flag set, and a raised flag always comes with an extreme code. They also check that the coefficient file holds steady across every edge at which calibration is inactive. Lane alignment, the exact weighted sum, the rounding at the half-code point, and when a newly written weight takes effect all depend on the history of the input bits. Only the bench's reference model can show these, by replaying that history against the outputs every clock under default weights, saturating patterns, gated writes and random weights.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  localparam int NUM_STAGES = 15;
  localparam int OUT_W      = 12;
  localparam int FRAC_W     = 4;
  localparam int COEF_W     = 16;

  // ideal binary weight of stage k in 1/2^frac code units
  function automatic logic [COEF_W-1:0] ideal_weight(input int k, input int out_w, input int frac_w);
    int e;
    e = out_w - 1 + frac_w - k;
    if (e < 0 || e >= COEF_W) return '0;
    return COEF_W'(1) << e;
  endfunction
endpackage

// File: rtl/pcc_deskew.sv
module pcc_deskew #(
  parameter int NUM_STAGES = 15
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_STAGES-1:0] raw_i,
  output logic [NUM_STAGES-1:0] aligned_o
);
  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_lane
    localparam int D = NUM_STAGES - 1 - k;
    if (D == 0) begin : g_pass
      assign aligned_o[k] = raw_i[k];
    end else if (D == 1) begin : g_one
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b0;
        else         q <= raw_i[k];
      end
      assign aligned_o[k] = q;
    end else begin : g_shift
      logic [D-1:0] sr;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr <= '0;
        else         sr <= {sr[D-2:0], raw_i[k]};
      end
      assign aligned_o[k] = sr[D-1];
    end
  end
endmodule

// File: rtl/pcc_coef_ram.sv
module pcc_coef_ram #(
  parameter int NUM_STAGES = 15,
  parameter int OUT_W      = 12,
  parameter int FRAC_W     = 4,
  parameter int COEF_W     = 16,
  parameter int ADDR_W     = $clog2(NUM_STAGES + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cal_active_i,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [COEF_W-1:0]            wdata_i,
  output logic [NUM_STAGES*COEF_W-1:0] weights_o,
  output logic [COEF_W-1:0]            offset_o
);
  import pcc_pkg::ideal_weight;

  logic wr_en;
  assign wr_en = cal_active_i && we_i;

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_w
    localparam logic [COEF_W-1:0] INIT = ideal_weight(k, OUT_W, FRAC_W);
    logic [COEF_W-1:0] w_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               w_q <= INIT;
      else if (wr_en && addr_i == ADDR_W'(k))    w_q <= wdata_i;
    end
    assign weights_o[k*COEF_W +: COEF_W] = w_q;
  end

  logic [COEF_W-1:0] off_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                        off_q <= '0;
    else if (wr_en && addr_i == ADDR_W'(NUM_STAGES))    off_q <= wdata_i;
  end
  assign offset_o = off_q;

  assert_write_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cal_active_i |=> $stable({weights_o, offset_o}));
endmodule

// File: rtl/pcc_accum.sv
module pcc_accum #(
  parameter int NUM_STAGES = 15,
  parameter int OUT_W      = 12,
  parameter int FRAC_W     = 4,
  parameter int COEF_W     = 16,
  parameter int SUM_W      = COEF_W + $clog2(NUM_STAGES + 1) + 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_STAGES-1:0]        bits_i,
  input  logic [NUM_STAGES*COEF_W-1:0] weights_i,
  input  logic [COEF_W-1:0]            offset_i,
  output logic [OUT_W-1:0]             code_o,
  output logic                         over_range_o
);
  localparam int HALF_I = 1 << (FRAC_W - 1);
  localparam int MAX_I  = (1 << OUT_W) - 1;
  localparam logic signed [SUM_W-1:0] HALF_V = SUM_W'(HALF_I);
  localparam logic signed [SUM_W-1:0] MAX_V  = SUM_W'(MAX_I);

  logic signed [SUM_W-1:0] sum_c, sum_q, rnd_c;
  logic                    lo_c, hi_c;

  always_comb begin
    sum_c = {{(SUM_W-COEF_W){offset_i[COEF_W-1]}}, offset_i};
    for (int k = 0; k < NUM_STAGES; k++) begin
      if (bits_i[k]) sum_c = sum_c + {{(SUM_W-COEF_W){1'b0}}, weights_i[k*COEF_W +: COEF_W]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_q <= '0;
    else         sum_q <= sum_c;
  end

  assign rnd_c = (sum_q + HALF_V) >>> FRAC_W;
  assign lo_c  = rnd_c < 0;
  assign hi_c  = rnd_c > MAX_V;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o       <= '0;
      over_range_o <= 1'b0;
    end else begin
      over_range_o <= lo_c || hi_c;
      if (lo_c)      code_o <= '0;
      else if (hi_c) code_o <= OUT_W'(MAX_I);
      else           code_o <= rnd_c[OUT_W-1:0];
    end
  end

  assert_floor_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rnd_c < 0) |=> (code_o == '0 && over_range_o));
  assert_ceiling_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rnd_c > MAX_V) |=> (code_o == OUT_W'(MAX_I) && over_range_o));
  assert_flag_extreme_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    over_range_o |-> (code_o == '0 || code_o == OUT_W'(MAX_I)));
endmodule

// File: rtl/pipe_corr_combiner.sv
module pipe_corr_combiner #(
  parameter int NUM_STAGES = pcc_pkg::NUM_STAGES,
  parameter int OUT_W      = pcc_pkg::OUT_W,
  parameter int FRAC_W     = pcc_pkg::FRAC_W,
  parameter int COEF_W     = pcc_pkg::COEF_W,
  parameter int ADDR_W     = $clog2(NUM_STAGES + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_STAGES-1:0] stage_bits_i,
  input  logic                  cal_active_i,
  input  logic                  coef_we_i,
  input  logic [ADDR_W-1:0]     coef_addr_i,
  input  logic [COEF_W-1:0]     coef_wdata_i,
  output logic [OUT_W-1:0]      code_o,
  output logic                  over_range_o
);
  logic [NUM_STAGES-1:0]        aligned;
  logic [NUM_STAGES*COEF_W-1:0] weights;
  logic [COEF_W-1:0]            offset;

  pcc_deskew #(.NUM_STAGES(NUM_STAGES)) u_deskew (
    .clk_i, .rst_ni, .raw_i(stage_bits_i), .aligned_o(aligned)
  );

  pcc_coef_ram #(
    .NUM_STAGES(NUM_STAGES), .OUT_W(OUT_W), .FRAC_W(FRAC_W),
    .COEF_W(COEF_W), .ADDR_W(ADDR_W)
  ) u_coef (
    .clk_i, .rst_ni, .cal_active_i, .we_i(coef_we_i), .addr_i(coef_addr_i),
    .wdata_i(coef_wdata_i), .weights_o(weights), .offset_o(offset)
  );

  pcc_accum #(
    .NUM_STAGES(NUM_STAGES), .OUT_W(OUT_W), .FRAC_W(FRAC_W), .COEF_W(COEF_W)
  ) u_accum (
    .clk_i, .rst_ni, .bits_i(aligned), .weights_i(weights), .offset_i(offset),
    .code_o, .over_range_o
  );
endmodule

// File: tb/pipe_corr_combiner_tb.sv
module pipe_corr_combiner_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [14:0] bits = '0;
  logic        cal = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [11:0] code;
  logic        ovr;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference model state
  int          coef_m[16];
  logic [14:0] hist[$];
  longint      sum_m;
  int          code_m;
  bit          ovr_m;

  always #2 clk = ~clk;

  pipe_corr_combiner u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .stage_bits_i(bits), .cal_active_i(cal),
    .coef_we_i(we), .coef_addr_i(addr), .coef_wdata_i(wdata),
    .code_o(code), .over_range_o(ovr)
  );

  task automatic model_reset();
    for (int k = 0; k < 15; k++) coef_m[k] = 1 << (15 - k);
    coef_m[15] = 0;
    hist.delete();
    for (int i = 0; i < 14; i++) hist.push_back('0);
    sum_m = 0; code_m = 0; ovr_m = 0;
  endtask

  // advance model across one rising edge using the currently driven inputs
  task automatic model_step();
    longint s, r;
    logic [14:0] cur;
    hist.push_back(bits);
    s = longint'($signed(16'(coef_m[15])));
    for (int k = 0; k < 15; k++) begin
      cur = hist[k];          // entry k is the cycle where stage k of this sample arrived
      if (cur[k]) s += longint'(coef_m[k]);
    end
    void'(hist.pop_front());
    r = sum_m + 8;
    r = (r >= 0) ? r / 16 : -((-r + 15) / 16);
    if (r < 0)         begin code_m = 0;    ovr_m = 1; end
    else if (r > 4095) begin code_m = 4095; ovr_m = 1; end
    else               begin code_m = int'(r); ovr_m = 0; end
    sum_m = s;
    if (cal && we) coef_m[addr] = int'(wdata);
  endtask

  task automatic compare(input string req);
    checks++;
    if (code !== 12'(code_m) || ovr !== ovr_m) begin
      errors++;
      $display("FAIL %s: code=%0d or=%0b expected code=%0d or=%0b", req, code, ovr, code_m, ovr_m);
    end
  endtask

  task automatic cyc(input logic [14:0] b, input logic c, input logic w,
                     input logic [3:0] a, input logic [15:0] d, input string req);
    @(negedge clk);
    compare(req);
    bits = b; cal = c; we = w; addr = a; wdata = d;
    model_step();
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    checks++;
    if (code !== '0 || ovr !== 1'b0) begin
      errors++;
      $display("FAIL R9: reset code=%0d or=%0b expected code=0 or=0", code, ovr);
    end
    rst_ni = 1'b1;
    model_step();

    // default ideal weights, random bits
    for (int i = 0; i < 300; i++) cyc(15'($urandom), 0, 0, 0, 0, "R1 R2 R3 R7 R9");
    // all stages high: rounds past full scale
    for (int i = 0; i < 30; i++) cyc('1, 0, 0, 0, 0, "R5");
    for (int i = 0; i < 30; i++) cyc('0, 0, 0, 0, 0, "R6");
    // walking single bit per stage
    for (int i = 0; i < 45; i++) cyc(15'(1) << (i % 15), 0, 0, 0, 0, "R1 R2");
    // gated writes ignored while calibration inactive
    for (int i = 0; i < 40; i++) cyc(15'($urandom), 0, 1, 4'($urandom), 16'hC000, "R8");
    for (int i = 0; i < 20; i++) cyc('0, 0, 0, 0, 0, "R8");
    // large negative offset: below zero
    cyc('0, 1, 1, 4'd15, 16'hF9C0, "R8");
    for (int i = 0; i < 20; i++) cyc('0, 0, 0, 0, 0, "R4");
    // rounding at the half-code point
    cyc('0, 1, 1, 4'd15, 16'd8, "R8");
    for (int i = 0; i < 8; i++) cyc('0, 0, 0, 0, 0, "R3");
    cyc('0, 1, 1, 4'd15, 16'd7, "R8");
    for (int i = 0; i < 8; i++) cyc('0, 0, 0, 0, 0, "R3");
    cyc('0, 1, 1, 4'd15, 16'hFFF8, "R8");
    for (int i = 0; i < 8; i++) cyc('0, 0, 0, 0, 0, "R3");
    cyc('0, 1, 1, 4'd15, 16'hFFF7, "R8");
    for (int i = 0; i < 8; i++) cyc('0, 0, 0, 0, 0, "R4");
    // random weights and offset loaded during calibration
    for (int a = 0; a < 15; a++) cyc(15'($urandom), 1, 1, 4'(a), 16'($urandom_range(0, 9000)), "R8");
    cyc(15'($urandom), 1, 1, 4'd15, 16'($urandom_range(0, 512)) - 16'd256, "R8");
    for (int i = 0; i < 300; i++) cyc(15'($urandom), 0, 0, 0, 0, "R2 R3 R4 R5 R6 R7");
    // writes interleaved with live samples
    for (int i = 0; i < 300; i++)
      cyc(15'($urandom), 1'($urandom), 1'($urandom), 4'($urandom),
          16'($urandom_range(0, 12000)), "R2 R8");
    for (int i = 0; i < 20; i++) cyc('1, 0, 0, 0, 0, "R2 R5");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule